// File: doc/BRIEF.md
# Flash Write Completion Poller

This block sits on the host side of a parallel flash device and decides when an internal program or erase has finished. Once the command sequence has been issued and its last write strobe has risen, the host pulses a start input. The poller then watches a ready/busy line, or keeps reading the location being written through a simple request/acknowledge read port. In the read-based modes it checks either the inverted-data bit (bit 7) or the alternating bit (bit 6) of each returned byte.

A status read can land on the exact cycle in which the device finishes. The bit that says "done" may then disagree with the rest of the byte. For that reason the poller never rejects on a single suspicious byte. It re-reads the same address twice and reports a rejection only when those confirmations do not both return the expected byte. A programmable cycle limit ends a poll that never completes, and that case is flagged as a timeout. Each result appears once as a one-cycle pulse and is also kept in sticky flags until the next start.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, busy, rdReq, donePulse, passPulse and all four sticky flags are 0.
- R2: startReq is taken only while busy is 0. Taking it latches the configuration inputs, clears all sticky flags and raises busy on the next cycle. A startReq while busy is 1 has no effect on the running operation or its result.
- R3: detMode encodes the method: 0 = ready/busy line, 1 = data polling on bit 7, 2 or 3 = toggle detection on bit 6. In mode 0 no read is ever requested, and the operation passes at the first clock edge on which rdyBusy is 1 (1 = ready, 0 = busy).
- R4: Every read holds rdReq at 1 until the clock edge where rdAck is 1, and rdData is taken on that edge. rdAddr equals the addrIn value latched at start for every read of the operation.
- R5: The target byte is expData when opErase is 0 (program) and 8'hFF when opErase is 1 (erase). In mode 1 a read shows completion when its bit 7 equals bit 7 of the target.
- R6: In modes 2 and 3 a read shows completion when its bit 6 equals bit 6 of the previous read of the same operation. The first read never shows completion.
- R7: When a read shows completion and the whole byte equals the target, the operation passes with no further reads.
- R8: When a read shows completion but the byte differs from the target, exactly two more reads follow. The operation passes only if both equal the target; otherwise it fails and stReject is set.
- R9: A cycle counter starts at 0 on the start edge and counts up once per busy cycle. In mode 0, or after a read that does not show completion, a count at or above timeoutLim ends the operation as a failure with stTimeout set. In mode 0 with rdyBusy held at 0, donePulse is high in the cycle after the (timeoutLim+1)-th clock edge following the start edge.
- R10: At the end of an operation, donePulse is high for one cycle, busy is 0 in that cycle, and passPulse is high in it only on a pass. stDone, and the one of stPass, stTimeout or stReject that applies, stay set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin polling; takes effect when idle |
| opErase | input | 1 | 1 = erase, 0 = program |
| detMode | input | 2 | Detection method (see R3) |
| expData | input | 8 | Byte that was programmed |
| addrIn | input | AW | Address of the location being written |
| timeoutLim | input | TW | Cycle limit before timeout |
| rdyBusy | input | 1 | Device ready (1) / busy (0) line |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdAddr | output | AW | Read address |
| rdAck | input | 1 | Read acknowledge; rdData valid with it |
| rdData | input | 8 | Byte returned by the read |
| busy | output | 1 | Operation in progress |
| donePulse | output | 1 | One-cycle completion pulse |
| passPulse | output | 1 | High with donePulse on a pass |
| stDone | output | 1 | Sticky: an operation has ended |
| stPass | output | 1 | Sticky: last operation passed |
| stTimeout | output | 1 | Sticky: last operation timed out |
| stReject | output | 1 | Sticky: last operation rejected after confirmation |

## Verification
The assertions assume the read port follows the handshake. rdAck comes only while rdReq is high and lasts one cycle per read, and the configuration inputs carry meaning only on the cycle startReq is taken. The bench's device model acknowledges each request one cycle after it appears and drops the acknowledge at once. It changes configuration only while the poller is idle, apart from one deliberate startReq during a busy wait. The model's responses follow a fixed rule: a number of in-progress bytes with inverted bit 7 and alternating bit 6, then final bytes, some of which can be corrupted in bit 0 so that the confirmation path is exercised.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

  localparam logic [1:0] MODE_RDYBSY = 2'd0;
  localparam logic [1:0] MODE_DATA   = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RBWAIT,
    ST_POLL,
    ST_CONF1,
    ST_CONF2
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic savePrev;
    logic saveOk1;
    logic finPass;
    logic finTimeout;
    logic finReject;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic rbMode;
    logic statusOk;
    logic byteMatch;
    logic timedOut;
    logic firstOk;
  } dpStatus_t;

endpackage

// File: rtl/fdp_dpath.sv
module fdp_dpath
  import fdp_pkg::*;
#(
  parameter int AW = 12,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic          busy,
  input  logic          opErase,
  input  logic [1:0]    detMode,
  input  logic [7:0]    expData,
  input  logic [AW-1:0] addrIn,
  input  logic [TW-1:0] timeoutLim,
  input  logic [7:0]    rdData,
  output dpStatus_t     stat,
  output logic [AW-1:0] rdAddr,
  output logic          donePulse,
  output logic          passPulse,
  output logic          stDone,
  output logic          stPass,
  output logic          stTimeout,
  output logic          stReject
);

  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};
  localparam int STAT_BIT = 7;
  localparam int TGL_BIT  = 6;

  logic [1:0]    modeQ;
  logic [7:0]    tgtQ;
  logic [AW-1:0] addrQ;
  logic [TW-1:0] limQ;
  logic [TW-1:0] cntQ;
  logic          prevTglQ;
  logic          havePrevQ;
  logic          ok1Q;
  logic          anyFin;

  assign anyFin = strobe.finPass | strobe.finTimeout | strobe.finReject;

  // configuration latched at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_RDYBSY;
      tgtQ  <= '0;
      addrQ <= '0;
      limQ  <= '0;
    end else if (strobe.load) begin
      modeQ <= detMode;
      tgtQ  <= opErase ? 8'hFF : expData;
      addrQ <= addrIn;
      limQ  <= timeoutLim;
    end
  end

  // cycle counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN)
      cntQ <= '0;
    else if (strobe.load)
      cntQ <= '0;
    else if (busy && cntQ != CNT_MAX)
      cntQ <= cntQ + 1'b1;
  end

  // history of the toggle bit and first confirmation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevTglQ  <= 1'b0;
      havePrevQ <= 1'b0;
      ok1Q      <= 1'b0;
    end else begin
      if (strobe.load)
        havePrevQ <= 1'b0;
      else if (strobe.savePrev) begin
        prevTglQ  <= rdData[TGL_BIT];
        havePrevQ <= 1'b1;
      end
      if (strobe.saveOk1)
        ok1Q <= (rdData == tgtQ);
    end
  end

  // result pulses and sticky flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      donePulse <= 1'b0;
      passPulse <= 1'b0;
      stDone    <= 1'b0;
      stPass    <= 1'b0;
      stTimeout <= 1'b0;
      stReject  <= 1'b0;
    end else begin
      donePulse <= anyFin;
      passPulse <= strobe.finPass;
      if (strobe.load) begin
        stDone    <= 1'b0;
        stPass    <= 1'b0;
        stTimeout <= 1'b0;
        stReject  <= 1'b0;
      end else begin
        if (anyFin)            stDone    <= 1'b1;
        if (strobe.finPass)    stPass    <= 1'b1;
        if (strobe.finTimeout) stTimeout <= 1'b1;
        if (strobe.finReject)  stReject  <= 1'b1;
      end
    end
  end

  always_comb begin
    stat.rbMode    = (modeQ == MODE_RDYBSY);
    stat.statusOk  = (modeQ == MODE_DATA) ? (rdData[STAT_BIT] == tgtQ[STAT_BIT])
                                          : (havePrevQ && rdData[TGL_BIT] == prevTglQ);
    stat.byteMatch = (rdData == tgtQ);
    stat.timedOut  = (cntQ >= limQ);
    stat.firstOk   = ok1Q;
  end

  assign rdAddr = addrQ;

  // R4: address does not move while an operation runs
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(strobe.load)) |-> $stable(rdAddr));

  // R9: a timeout is never also a pass or a rejection
  a_r9_timeout_excl: assert property (@(posedge clk) disable iff (!rstN)
    stTimeout |-> (!stPass && !stReject));

  // R8: rejection and pass never coexist
  a_r8_reject_excl: assert property (@(posedge clk) disable iff (!rstN)
    stReject |-> !stPass);

  // R10: sticky flags only appear together with stDone
  a_r10_sticky_done: assert property (@(posedge clk) disable iff (!rstN)
    (stPass || stTimeout || stReject) |-> stDone);

endmodule

// File: rtl/fdp_ctrl.sv
module fdp_ctrl
  import fdp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] detMode,
  input  logic       rdyBusy,
  input  logic       rdAck,
  input  dpStatus_t  stat,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       rdReq
);

  pollState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          strobe.load = 1'b1;
          stateD = (detMode == MODE_RDYBSY) ? ST_RBWAIT : ST_POLL;
        end
      end
      ST_RBWAIT: begin
        if (rdyBusy) begin
          strobe.finPass = 1'b1;
          stateD = ST_IDLE;
        end else if (stat.timedOut) begin
          strobe.finTimeout = 1'b1;
          stateD = ST_IDLE;
        end
      end
      ST_POLL: begin
        if (rdAck) begin
          strobe.savePrev = 1'b1;
          if (stat.statusOk) begin
            if (stat.byteMatch) begin
              strobe.finPass = 1'b1;
              stateD = ST_IDLE;
            end else begin
              stateD = ST_CONF1;
            end
          end else if (stat.timedOut) begin
            strobe.finTimeout = 1'b1;
            stateD = ST_IDLE;
          end
        end
      end
      ST_CONF1: begin
        if (rdAck) begin
          strobe.saveOk1 = 1'b1;
          stateD = ST_CONF2;
        end
      end
      ST_CONF2: begin
        if (rdAck) begin
          if (stat.firstOk && stat.byteMatch) strobe.finPass = 1'b1;
          else                                 strobe.finReject = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy  = (stateQ != ST_IDLE);
  assign rdReq = (stateQ == ST_POLL) || (stateQ == ST_CONF1) || (stateQ == ST_CONF2);

  // R4: an unanswered request stays up
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq);

  // R3: ready/busy mode never reads the device
  a_r3_rb_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stat.rbMode) |-> !rdReq);

  // R2: a start pulse while busy leaves the state machine busy
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !strobe.finPass && !strobe.finTimeout && !strobe.finReject) |=> busy);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int AW = 12,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          opErase,
  input  logic [1:0]    detMode,
  input  logic [7:0]    expData,
  input  logic [AW-1:0] addrIn,
  input  logic [TW-1:0] timeoutLim,
  input  logic          rdyBusy,
  output logic          rdReq,
  output logic [AW-1:0] rdAddr,
  input  logic          rdAck,
  input  logic [7:0]    rdData,
  output logic          busy,
  output logic          donePulse,
  output logic          passPulse,
  output logic          stDone,
  output logic          stPass,
  output logic          stTimeout,
  output logic          stReject
);

  ctlStrobe_t strobe;
  dpStatus_t  stat;

  fdp_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .detMode  (detMode),
    .rdyBusy  (rdyBusy),
    .rdAck    (rdAck),
    .stat     (stat),
    .strobe   (strobe),
    .busy     (busy),
    .rdReq    (rdReq)
  );

  fdp_dpath #(.AW(AW), .TW(TW)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busy       (busy),
    .opErase    (opErase),
    .detMode    (detMode),
    .expData    (expData),
    .addrIn     (addrIn),
    .timeoutLim (timeoutLim),
    .rdData     (rdData),
    .stat       (stat),
    .rdAddr     (rdAddr),
    .donePulse  (donePulse),
    .passPulse  (passPulse),
    .stDone     (stDone),
    .stPass     (stPass),
    .stTimeout  (stTimeout),
    .stReject   (stReject)
  );

  // R10: leaving busy always comes with the completion pulse
  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> donePulse);

  // R10: pass pulse only inside a done pulse
  a_r10_pass_in_done: assert property (@(posedge clk) disable iff (!rstN)
    passPulse |-> donePulse);

  // R10: no read is outstanding when the result is reported
  a_r10_done_no_req: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !rdReq);

endmodule

// File: tb/test_flash_done_poller.sv
module test_flash_done_poller;

  localparam int AW = 12;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          opErase = 1'b0;
  logic [1:0]    detMode = 2'd0;
  logic [7:0]    expData = 8'h00;
  logic [AW-1:0] addrIn = '0;
  logic [TW-1:0] timeoutLim = '1;
  logic          rdyBusy = 1'b0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdAck;
  logic [7:0]    rdData;
  logic          busy, donePulse, passPulse;
  logic          stDone, stPass, stTimeout, stReject;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // device model configuration (changed only while idle)
  int          mNb = 0;
  logic [3:0]  mBad = 4'h0;
  logic [7:0]  mTgt = 8'h00;
  logic        mEr = 1'b0;
  int          readCnt = 0;
  int          addrErr = 0;
  logic        ackR = 1'b0;
  logic [7:0]  dataR = 8'h00;

  always #2 clk = ~clk;

  flash_done_poller #(.AW(AW), .TW(TW)) i_flash_done_poller (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opErase(opErase),
    .detMode(detMode), .expData(expData), .addrIn(addrIn),
    .timeoutLim(timeoutLim), .rdyBusy(rdyBusy), .rdReq(rdReq),
    .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData), .busy(busy),
    .donePulse(donePulse), .passPulse(passPulse), .stDone(stDone),
    .stPass(stPass), .stTimeout(stTimeout), .stReject(stReject)
  );

  assign rdAck  = ackR;
  assign rdData = dataR;

  // in-progress bytes: bit 7 inverted (program) or 0 (erase), bit 6 alternating
  function automatic logic [7:0] respByte(int k, int nb, logic [3:0] bad,
                                          logic [7:0] tgt, logic er);
    logic [7:0] b;
    if (k < nb) begin
      b = {(er ? 1'b0 : ~tgt[7]), k[0], 6'h15};
    end else if ((k - nb) < 4 && bad[k - nb]) begin
      b = tgt ^ 8'h01;
    end else begin
      b = tgt;
    end
    return b;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      ackR <= 1'b0;
    end else begin
      if (startReq && !busy) readCnt <= 0;
      ackR <= rdReq && !ackR;
      if (rdReq && !ackR) begin
        dataR   <= respByte(readCnt, mNb, mBad, mTgt, mEr);
        readCnt <= readCnt + 1;
        if (rdAddr != addrIn) addrErr <= addrErr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected outcome of a read-based poll, from the requirements
  task automatic refPoll(input logic [1:0] mode, input int nb, input logic [3:0] bad,
                         input logic [7:0] tgt, input logic er,
                         output bit pass, output int reads);
    bit havePrev = 0;
    logic prevT = 1'b0;
    pass = 0;
    reads = -1;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b;
      bit ok;
      b = respByte(i, nb, bad, tgt, er);
      ok = (mode == 2'd1) ? (b[7] == tgt[7]) : (havePrev && b[6] == prevT);
      prevT = b[6];
      havePrev = 1;
      if (ok) begin
        if (b == tgt) begin
          pass = 1; reads = i + 1;
        end else begin
          pass = (respByte(i + 1, nb, bad, tgt, er) == tgt) &&
                 (respByte(i + 2, nb, bad, tgt, er) == tgt);
          reads = i + 3;
        end
        return;
      end
    end
  endtask

  task automatic doStart(input logic [1:0] mode, input logic er, input logic [7:0] ed,
                         input logic [AW-1:0] ad, input logic [TW-1:0] lim);
    @(negedge clk);
    detMode = mode; opErase = er; expData = ed; addrIn = ad; timeoutLim = lim;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk({stDone, stPass, stTimeout, stReject} == 4'b0, "R2", "sticky cleared",
        {stDone, stPass, stTimeout, stReject}, 0);
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (!donePulse && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(donePulse == 1'b1, "R10", "donePulse seen", donePulse, 1);
    chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
  endtask

  task automatic pollRun(input logic [1:0] mode, input logic er, input int nb,
                         input logic [3:0] bad, input logic [7:0] ed, input logic [AW-1:0] ad);
    bit expPass;
    int expReads, n, a0;
    logic [7:0] tgt;
    tgt = er ? 8'hFF : ed;
    mNb = nb; mBad = bad; mTgt = tgt; mEr = er;
    refPoll(mode, nb, bad, tgt, er, expPass, expReads);
    a0 = addrErr;
    doStart(mode, er, ed, ad, '1);
    waitDone(n);
    chk(passPulse == expPass, expPass ? "R7" : "R8", "passPulse", passPulse, expPass);
    chk(stReject == !expPass, "R8", "stReject", stReject, !expPass);
    chk(stPass == expPass && stDone, "R10", "stPass", stPass, expPass);
    chk(readCnt == expReads, (mode == 2'd1) ? "R5" : "R6", "read count", readCnt, expReads);
    chk(addrErr == a0, "R4", "address errors", addrErr - a0, 0);
    @(negedge clk);
    chk(donePulse == 1'b0, "R10", "done is one cycle", donePulse, 0);
  endtask

  initial begin : watchdog
    wait (cyc >= 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, rdReq, donePulse, passPulse} == 4'b0, "R1", "outputs in reset",
        {busy, rdReq, donePulse, passPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, rdReq, donePulse, passPulse, stDone, stPass, stTimeout, stReject} == 8'b0,
        "R1", "outputs after reset",
        {busy, rdReq, donePulse, passPulse, stDone, stPass, stTimeout, stReject}, 0);

    // R9: ready/busy timeout exact cycle count
    for (int lim = 0; lim < 8; lim++) begin
      rdyBusy = 1'b0;
      doStart(2'd0, 1'b0, 8'h00, 12'h123, lim[TW-1:0]);
      waitDone(n);
      chk(n == lim + 1, "R9", "timeout cycle", n, lim + 1);
      chk(stTimeout && !passPulse && !stPass, "R9", "timeout flags",
          {stTimeout, passPulse, stPass}, 3'b100);
      chk(readCnt == 0, "R3", "no reads in ready/busy mode", readCnt, 0);
    end

    // R3, R2: ready/busy pass, with a start pulse while busy ignored
    for (int d = 0; d < 6; d++) begin
      rdyBusy = 1'b0;
      doStart(2'd0, 1'b1, 8'h00, 12'h0F0, 16'd100);
      repeat (d) @(negedge clk);
      detMode = 2'd1; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      chk(busy == 1'b1 && rdReq == 1'b0, "R2", "start while busy ignored",
          {busy, rdReq}, 2'b10);
      rdyBusy = 1'b1;
      waitDone(n);
      chk(n == 1, "R3", "pass edge after ready", n, 1);
      chk(passPulse && stPass && !stTimeout, "R3", "ready pass flags",
          {passPulse, stPass, stTimeout}, 3'b110);
      chk(readCnt == 0, "R2", "no reads after ignored start", readCnt, 0);
      rdyBusy = 1'b0;
    end

    // R10: sticky flags hold
    repeat (4) @(negedge clk);
    chk(stDone && stPass && !donePulse, "R10", "sticky hold",
        {stDone, stPass, donePulse}, 3'b110);

    // R5..R8: sweep modes, operations, busy lengths and corruption patterns
    for (int m = 1; m <= 3; m++)
      for (int er = 0; er < 2; er++)
        for (int nb = 0; nb < 6; nb++)
          for (int bad = 0; bad < 8; bad++) begin
            logic [7:0] ed;
            ed = 8'(nb * 53 + bad * 29 + m * 71 + 11);
            if (m == 3 && bad > 1) continue;
            pollRun(m[1:0], er[0], nb, bad[3:0], ed, 12'(nb * 97 + bad * 5 + 1));
          end

    // R9: polling timeout when completion never shows
    mNb = 100000; mBad = 4'h0; mTgt = 8'hA5; mEr = 1'b0;
    doStart(2'd1, 1'b0, 8'hA5, 12'h3AA, 16'd20);
    waitDone(n);
    chk(stTimeout && !passPulse && !stReject, "R9", "poll timeout flags",
        {stTimeout, passPulse, stReject}, 3'b100);
    chk(readCnt > 0, "R9", "reads before poll timeout", readCnt, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule